// File: doc/BRIEF.md
# Equal-Pair Tracking Moore Machine

This block watches two single-bit synchronous inputs, `a_in` and `b_in`, and raises `z_out` when the last two values of `a_in` seen on clock edges were equal. Once raised, `z_out` also stays high for as long as `b_in` keeps reading 1 on each following edge. The first edge where `b_in` is 0 ends that hold. From then on, only a fresh pair of equal `a_in` samples can raise `z_out` again.

The block is a five-state Moore machine. `z_out` depends on the state alone and is held in a flip-flop. Its value is computed from the next state, so it changes on the same edge as the state register. The 3-bit state code is brought out on `state_code` so that a debugger or a neighbouring block can see which state the machine is in.

A synchronous, active-high reset puts the machine in its start state. It must be applied after power-up before the output is meaningful.

Top module: `eqp_tracker`

## Requirements
- R1: With `rst` high at a rising edge, the next state is the start state (code 3'd0) and `z_out` is 0.
- R2: From the start state, the next edge moves to code 3'd1 if `a_in` is 0, or to code 3'd2 if it is 1. In both cases `z_out` is 0.
- R3: In code 3'd1 with `a_in`=0, the next state is code 3'd3 with `z_out`=1. In code 3'd2 with `a_in`=1, the next state is code 3'd4 with `z_out`=1.
- R4: In code 3'd1 with `a_in`=1, the next state is code 3'd2. In code 3'd2 with `a_in`=0, the next state is code 3'd1. `z_out` is 0 after either move.
- R5: In code 3'd3 or 3'd4 with `b_in`=1, the next state is code 3'd4 if `a_in` is 1, or code 3'd3 if `a_in` is 0. `z_out` stays 1.
- R6: In code 3'd3 with `b_in`=0 and `a_in`=1, the next state is code 3'd2. In code 3'd4 with `b_in`=0 and `a_in`=0, the next state is code 3'd1. `z_out` is 0 after either move.
- R7: In code 3'd3 or 3'd4 with `b_in`=0, an `a_in` that equals the last sampled value keeps the machine in the same code, with `z_out`=1. This is how a run of three or more equal values is handled.
- R8: `state_code` only ever shows codes 3'd0 to 3'd4. Any of the codes 3'd5 to 3'd7 goes to code 3'd0 on the next edge.
- R9: `z_out` is 1 exactly when `state_code` is 3'd3 or 3'd4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Input whose consecutive equal values are detected |
| b_in | input | 1 | Hold input that keeps `z_out` high after a match |
| z_out | output | 1 | Registered Moore output |
| state_code | output | 3 | Current state code, for debug |

## Verification
The assertions assume that `a_in` and `b_in` are synchronous to `clk`, hold known values and are stable around each rising edge. They also assume that `rst` is high at the first edges, so the state register never starts from an unknown code. The stimulus changes `a_in`, `b_in` and `rst` only on falling edges, and it asserts reset before any other activity. Later resets appear only as whole-cycle pulses.

// File: rtl/eqp_pkg.sv
package eqp_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_START  = 3'd0,
    ST_SAW0   = 3'd1,
    ST_SAW1   = 3'd2,
    ST_MATCH0 = 3'd3,
    ST_MATCH1 = 3'd4
  } eqp_state_e;

  function automatic logic is_match(input eqp_state_e s);
    return (s == ST_MATCH0) || (s == ST_MATCH1);
  endfunction
endpackage

// File: rtl/eqp_next.sv
module eqp_next
  import eqp_pkg::*;
(
  input  eqp_state_e cur_i,
  input  logic       a_i,
  input  logic       b_i,
  output eqp_state_e nxt_o
);
  always_comb begin
    case (cur_i)
      ST_START:  nxt_o = a_i ? ST_SAW1 : ST_SAW0;
      ST_SAW0:   nxt_o = a_i ? ST_SAW1 : ST_MATCH0;
      ST_SAW1:   nxt_o = a_i ? ST_MATCH1 : ST_SAW0;
      ST_MATCH0: begin
        if (b_i) nxt_o = a_i ? ST_MATCH1 : ST_MATCH0;
        else     nxt_o = a_i ? ST_SAW1 : ST_MATCH0;
      end
      ST_MATCH1: begin
        if (b_i) nxt_o = a_i ? ST_MATCH1 : ST_MATCH0;
        else     nxt_o = a_i ? ST_MATCH1 : ST_SAW0;
      end
      default:   nxt_o = ST_START;
    endcase
  end
endmodule

// File: rtl/eqp_zdec.sv
module eqp_zdec
  import eqp_pkg::*;
(
  input  eqp_state_e st_i,
  output logic       z_o
);
  always_comb z_o = is_match(st_i);
endmodule

// File: rtl/eqp_tracker.sv
module eqp_tracker
  import eqp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               a_in,
  input  logic               b_in,
  output logic               z_out,
  output logic [STATE_W-1:0] state_code
);
  eqp_state_e cur_q;
  eqp_state_e nxt;
  logic       z_nxt;

  eqp_next u_next (
    .cur_i (cur_q),
    .a_i   (a_in),
    .b_i   (b_in),
    .nxt_o (nxt)
  );

  eqp_zdec u_zdec (
    .st_i (nxt),
    .z_o  (z_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= ST_START;
      z_out <= 1'b0;
    end else begin
      cur_q <= nxt;
      z_out <= z_nxt;
    end
  end

  assign state_code = cur_q;

  // R1
  rst_to_start_chk: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0) && !z_out);

  // R2
  start_leaves_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_START) |=> (state_code == 3'd1 || state_code == 3'd2) && !z_out);

  // R3
  pair_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_q == ST_SAW0 && !a_in) |=> (state_code == 3'd3) && z_out);

  // R5
  hold_match_chk: assert property (@(posedge clk) disable iff (rst)
    (is_match(cur_q) && b_in) |=> z_out && (state_code == ($past(a_in) ? 3'd4 : 3'd3)));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd4);

  // R9
  z_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    z_out == (state_code == 3'd3 || state_code == 3'd4));
endmodule

// File: tb/eqp_tracker_tb.sv
`timescale 1ns/1ps
module eqp_tracker_tb;
  typedef struct {
    logic       z;
    logic [2:0] code;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a_in = 1'b0;
  logic       b_in = 1'b0;
  logic       z_out;
  logic [2:0] state_code;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  bit m_have = 1'b0;
  bit m_pa = 1'b0;
  bit m_z = 1'b0;

  always #2.5 clk = ~clk;

  eqp_tracker u_dut (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .z_out      (z_out),
    .state_code (state_code)
  );

  task automatic step(input bit ra, input bit rb, input bit rr);
    exp_t e;
    bit   eq;
    @(negedge clk);
    a_in = ra;
    b_in = rb;
    rst  = rr;
    if (rr) begin
      e.tag = "R1";
      e.z = 1'b0;
      e.code = 3'd0;
      m_have = 1'b0;
      m_z = 1'b0;
    end else begin
      eq = m_have && (ra == m_pa);
      if (!m_have)          e.tag = "R2";
      else if (m_z && rb)   e.tag = "R5";
      else if (m_z && eq)   e.tag = "R7";
      else if (m_z)         e.tag = "R6";
      else if (eq)          e.tag = "R3";
      else                  e.tag = "R4";
      e.z = eq || (m_z && rb);
      e.code = e.z ? (ra ? 3'd4 : 3'd3) : (ra ? 3'd2 : 3'd1);
      m_have = 1'b1;
      m_pa = ra;
      m_z = e.z;
    end
    sb.push_back(e);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_checks++;
        if (z_out !== e.z) begin
          n_fail++;
          $display("FAIL %s z_out actual=%b expected=%b", e.tag, z_out, e.z);
        end
        n_checks++;
        if (state_code !== e.code) begin
          n_fail++;
          $display("FAIL %s state_code actual=%0d expected=%0d", e.tag, state_code, e.code);
        end
        n_checks++;
        if (!(state_code <= 3'd4)) begin
          n_fail++;
          $display("FAIL R8 state_code actual=%0d expected=0..4", state_code);
        end
        n_checks++;
        if (z_out !== (state_code == 3'd3 || state_code == 3'd4)) begin
          n_fail++;
          $display("FAIL R9 z_out actual=%b expected=%b", z_out,
                   (state_code == 3'd3 || state_code == 3'd4));
        end
      end
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    step(0, 0, 1); step(0, 0, 1);                 // R1
    step(0, 0, 0); step(0, 0, 0);                 // R2 then R3 low pair
    step(0, 0, 0); step(0, 0, 0);                 // R7 run of zeros
    step(1, 0, 0); step(0, 0, 0); step(1, 0, 0);  // R6, R4 alternation
    step(1, 0, 0); step(1, 0, 0);                 // R3 high pair, R7
    step(0, 1, 0); step(1, 1, 0); step(0, 1, 0);  // R5 hold across A changes
    step(0, 0, 0); step(1, 0, 0);                 // R7 then R6
    step(1, 1, 0); step(0, 0, 0);                 // R3 then R6 from high match
    step(1, 1, 1);                                // R1 mid-run
    step(1, 1, 0); step(0, 1, 0);                 // R2, R4 with B ignored
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] | lfsr[2], (lfsr == 8'h3C));
    end
    step(0, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule